// File: doc/BRIEF.md
# Second-Level Interrupt Router with Bypass

This block collects up to 32 level-sensitive peripheral interrupt lines and presents them to a parent interrupt controller on several grouped outputs. Software controls which lines take part through one enable word. It can observe the raw state of every line through one read-only status word. Each grouped output has its own compile-time map mask. A grouped output goes high when any line that is both enabled and selected by that mask is active.

A compile-time forward mask marks lines that have their own gate. Serial-port interrupts are the typical case. A marked line skips the enable word and the grouping. Its raw level goes, one clock later, to a dedicated bypass output with the same index, which the parent wires to its own input.

Bit positions that appear in no map mask and not in the forward mask have no effect on any output. The register bus has two word registers, a single-cycle write and a fixed one-cycle read. There are no set-bit or clear-bit operations, so software changes the enable word by writing all of it.

Top module: `irq_router`

## Requirements
- R1: After reset the enable word is 0, every grouped output and every bypass output is low, and `busRdValid` is low.
- R2: A write with `busAddr` = 0x0 replaces all 32 bits of the enable word (bit i enables source i) at that clock edge. Writes to offset 0x4 or to any other offset leave the enable word unchanged.
- R3: Grouped output g is high one clock after a cycle in which some source i has `srcIrq[i]`=1, enable bit i=1, map bit i of group g=1 and forward bit i=0. In every other case it is low one clock later. Default map masks: group 0 = 0x00000EB8, group 1 = 0x00000140.
- R4: A source whose bit is set in no map mask and not in the forward mask never raises any output, whatever the enable word holds. With the defaults these are sources 12 to 31.
- R5: For a source whose forward bit is set, `fwdIrq[i]` equals `srcIrq[i]` one clock later, regardless of the enable word. Such a source never contributes to a grouped output. Default forward mask = 0x00000007.
- R6: For a source whose forward bit is clear, `fwdIrq[i]` stays low.
- R7: A read with `busAddr` = 0x4 returns the raw source lines as sampled at the request edge, with bit i = source i. The enable word does not affect this value, and writes cannot change it.
- R8: `busRdValid` and `busRdData` appear exactly one clock after a cycle with `busRdEn` high. A read at 0x0 returns the enable word. A read at any offset other than 0x0 or 0x4 returns 0. `busRdValid` is low in cycles that follow no read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busWrEn | input | 1 | Write strobe |
| busRdEn | input | 1 | Read strobe |
| busAddr | input | 3 | Byte offset of the access |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Read data, valid with busRdValid |
| busRdValid | output | 1 | Read data valid, one clock after busRdEn |
| srcIrq | input | 32 | Level-sensitive source interrupt lines |
| grpIrq | output | 2 | Grouped outputs to the parent controller |
| fwdIrq | output | 32 | Per-source bypass outputs |

## Verification
The assertions assume that the source lines and bus strobes are synchronous to `clk` and settled before each rising edge. They also assume that reset is held low from time zero for at least one edge. The stimulus changes every input on the falling edge and holds reset low for several cycles before any access. The bus checks assume a read and a write may share a cycle. The stimulus issues them separately, so each read observes a settled enable word.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;

  localparam int unsigned OFS_ENABLE = 0;
  localparam int unsigned OFS_STATUS = 4;

  typedef struct packed {
    logic wrEnable;
    logic rdAny;
    logic rdEnable;
    logic rdStatus;
  } regStrobe_t;

endpackage

// File: rtl/irq_router_ctrl.sv
module irq_router_ctrl
  import irq_router_pkg::*;
#(
  parameter int unsigned ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic [ADDR_W-1:0] busAddr,
  output regStrobe_t        strobe,
  output logic              busRdValid
);

  localparam logic [ADDR_W-1:0] ADR_EN = ADDR_W'(OFS_ENABLE);
  localparam logic [ADDR_W-1:0] ADR_ST = ADDR_W'(OFS_STATUS);

  logic hitEnable;
  logic hitStatus;
  logic rdValidQ;

  assign hitEnable = (busAddr == ADR_EN);
  assign hitStatus = (busAddr == ADR_ST);

  always_comb begin
    strobe          = '0;
    strobe.wrEnable = busWrEn && hitEnable;
    strobe.rdAny    = busRdEn;
    strobe.rdEnable = busRdEn && hitEnable;
    strobe.rdStatus = busRdEn && hitStatus;
  end

  always_ff @(posedge clk) begin
    if (!rstN) rdValidQ <= 1'b0;
    else       rdValidQ <= busRdEn;
  end

  assign busRdValid = rdValidQ;

  AST_RD_LATENCY: assert property (@(posedge clk) disable iff (!rstN)
    busRdEn |=> busRdValid); // R8
  AST_RD_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rstN)
    !busRdEn |=> !busRdValid); // R8

endmodule

// File: rtl/irq_router_dp.sv
module irq_router_dp
  import irq_router_pkg::*;
#(
  parameter int unsigned              SRC_W     = 32,
  parameter int unsigned              NUM_GRP   = 2,
  parameter logic [NUM_GRP*SRC_W-1:0] GRP_MASKS = {32'h0000_0140, 32'h0000_0EB8},
  parameter logic [SRC_W-1:0]         FWD_MASK  = 32'h0000_0007
) (
  input  logic               clk,
  input  logic               rstN,
  input  regStrobe_t         strobe,
  input  logic [SRC_W-1:0]   busWrData,
  input  logic [SRC_W-1:0]   srcIrq,
  output logic [SRC_W-1:0]   busRdData,
  output logic [NUM_GRP-1:0] grpIrq,
  output logic [SRC_W-1:0]   fwdIrq
);

  logic [SRC_W-1:0]   enableQ;
  logic [SRC_W-1:0]   rdDataQ;
  logic [SRC_W-1:0]   fwdQ;
  logic [SRC_W-1:0]   gatedSrc;
  logic [NUM_GRP-1:0] grpQ;

  // Enable word: whole-word replace only
  always_ff @(posedge clk) begin
    if (!rstN)                enableQ <= '0;
    else if (strobe.wrEnable) enableQ <= busWrData;
  end

  // Read data, one cycle after the request
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdDataQ <= '0;
    end else if (strobe.rdAny) begin
      if (strobe.rdEnable)      rdDataQ <= enableQ;
      else if (strobe.rdStatus) rdDataQ <= srcIrq;
      else                      rdDataQ <= '0;
    end
  end

  // Forwarded sources never join a group
  assign gatedSrc = srcIrq & enableQ & ~FWD_MASK;

  generate
    for (genvar g = 0; g < NUM_GRP; g++) begin : gGroup
      localparam logic [SRC_W-1:0] MAP = GRP_MASKS[g*SRC_W +: SRC_W];
      always_ff @(posedge clk) begin
        if (!rstN) grpQ[g] <= 1'b0;
        else       grpQ[g] <= |(gatedSrc & MAP);
      end

      AST_GRP_QUIET: assert property (@(posedge clk) disable iff (!rstN)
        ((srcIrq & enableQ & MAP & ~FWD_MASK) == '0) |=> !grpIrq[g]); // R3
    end
  endgenerate

  // Bypass lines: one flop each, enable word not involved
  generate
    for (genvar i = 0; i < SRC_W; i++) begin : gFwd
      if (FWD_MASK[i]) begin : gGate
        always_ff @(posedge clk) begin
          if (!rstN) fwdQ[i] <= 1'b0;
          else       fwdQ[i] <= srcIrq[i];
        end
      end else begin : gTie
        assign fwdQ[i] = 1'b0;
      end
    end
  endgenerate

  assign busRdData = rdDataQ;
  assign grpIrq    = grpQ;
  assign fwdIrq    = fwdQ;

  AST_ENABLE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.wrEnable |=> $stable(enableQ)); // R2
  AST_FWD_TRACK: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (fwdIrq == ($past(srcIrq) & FWD_MASK))); // R5
  AST_STATUS_READ: assert property (@(posedge clk) disable iff (!rstN)
    strobe.rdStatus |=> (busRdData == $past(srcIrq))); // R7

endmodule

// File: rtl/irq_router.sv
module irq_router
  import irq_router_pkg::*;
#(
  parameter int unsigned              SRC_W     = 32,
  parameter int unsigned              NUM_GRP   = 2,
  parameter int unsigned              ADDR_W    = 3,
  parameter logic [NUM_GRP*SRC_W-1:0] GRP_MASKS = {32'h0000_0140, 32'h0000_0EB8},
  parameter logic [SRC_W-1:0]         FWD_MASK  = 32'h0000_0007
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               busWrEn,
  input  logic               busRdEn,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic [SRC_W-1:0]   busWrData,
  output logic [SRC_W-1:0]   busRdData,
  output logic               busRdValid,
  input  logic [SRC_W-1:0]   srcIrq,
  output logic [NUM_GRP-1:0] grpIrq,
  output logic [SRC_W-1:0]   fwdIrq
);

  regStrobe_t strobe;

  irq_router_ctrl #(.ADDR_W(ADDR_W)) uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .busWrEn    (busWrEn),
    .busRdEn    (busRdEn),
    .busAddr    (busAddr),
    .strobe     (strobe),
    .busRdValid (busRdValid)
  );

  irq_router_dp #(
    .SRC_W     (SRC_W),
    .NUM_GRP   (NUM_GRP),
    .GRP_MASKS (GRP_MASKS),
    .FWD_MASK  (FWD_MASK)
  ) uDp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .busWrData (busWrData),
    .srcIrq    (srcIrq),
    .busRdData (busRdData),
    .grpIrq    (grpIrq),
    .fwdIrq    (fwdIrq)
  );

endmodule

// File: tb/irq_router_test.sv
`timescale 1ns/1ps
module irq_router_test;

  localparam logic [31:0] MAP0 = 32'h0000_0EB8;
  localparam logic [31:0] MAP1 = 32'h0000_0140;
  localparam logic [31:0] FWD  = 32'h0000_0007;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busWrEn = 1'b0;
  logic        busRdEn = 1'b0;
  logic [2:0]  busAddr = '0;
  logic [31:0] busWrData = '0;
  logic [31:0] busRdData;
  logic        busRdValid;
  logic [31:0] srcIrq = '0;
  logic [1:0]  grpIrq;
  logic [31:0] fwdIrq;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  irq_router uut (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busRdEn(busRdEn),
    .busAddr(busAddr), .busWrData(busWrData), .busRdData(busRdData),
    .busRdValid(busRdValid), .srcIrq(srcIrq), .grpIrq(grpIrq), .fwdIrq(fwdIrq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [2:0] addr, input logic [31:0] data);
    @(negedge clk);
    busWrEn = 1'b1; busAddr = addr; busWrData = data;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic busRead(input logic [2:0] addr, output logic [31:0] data, output logic valid);
    @(negedge clk);
    busRdEn = 1'b1; busAddr = addr;
    @(negedge clk);
    busRdEn = 1'b0;
    data = busRdData; valid = busRdValid;
  endtask

  function automatic logic [1:0] expGrp(input logic [31:0] s, input logic [31:0] e);
    logic [31:0] live = s & e & ~FWD;
    return {|(live & MAP1), |(live & MAP0)};
  endfunction

  task automatic applyAndCheck(input logic [31:0] s, input logic [31:0] e, input string tag);
    @(negedge clk);
    srcIrq = s;
    @(negedge clk);
    @(negedge clk);
    check({tag, " grp"}, {30'd0, grpIrq}, {30'd0, expGrp(s, e)});
    check({tag, " fwd"}, fwdIrq, s & FWD);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] rd;
    logic        vld;
    logic [31:0] lfsr;
    logic [31:0] en;
    repeat (4) @(negedge clk);
    srcIrq = 32'hFFFF_FFFF;
    @(negedge clk);
    // R1: reset state, with every source line held high
    check("R1 grp", {30'd0, grpIrq}, 32'd0);
    check("R1 fwd", fwdIrq, 32'd0);
    check("R1 rdValid", {31'd0, busRdValid}, 32'd0);
    rstN = 1'b1;
    srcIrq = '0;
    busRead(3'd0, rd, vld);
    check("R1 enable", rd, 32'd0);
    check("R8 valid", {31'd0, vld}, 32'd1);
    @(negedge clk);
    check("R8 valid idle", {31'd0, busRdValid}, 32'd0);

    // R2: whole-word write, ignored offsets
    busWrite(3'd0, 32'hFFFF_FFFF);
    busRead(3'd0, rd, vld);
    check("R2 write", rd, 32'hFFFF_FFFF);
    busWrite(3'd4, 32'h0);
    busWrite(3'd2, 32'h0);
    busRead(3'd0, rd, vld);
    check("R2 ignored offsets", rd, 32'hFFFF_FFFF);

    // Single-source sweep, everything enabled
    for (int i = 0; i < 32; i++) begin
      logic [31:0] s = 32'd1 << i;
      if (((MAP0 | MAP1 | FWD) & s) == 0) applyAndCheck(s, 32'hFFFF_FFFF, "R4 unmapped");
      else if ((FWD & s) != 0)            applyAndCheck(s, 32'hFFFF_FFFF, "R5 forwarded");
      else                                applyAndCheck(s, 32'hFFFF_FFFF, "R3 grouped");
    end
    // R4: all unmapped sources together
    applyAndCheck(~(MAP0 | MAP1 | FWD), 32'hFFFF_FFFF, "R4 all unmapped");

    // Everything disabled: groups silent, bypass still live
    busWrite(3'd0, 32'h0);
    for (int i = 0; i < 32; i++) begin
      applyAndCheck(32'd1 << i, 32'h0, "R5 disabled");
    end
    applyAndCheck(32'hFFFF_FFFF, 32'h0, "R3 all off");
    // R6: non-forwarded bypass bits stay low
    check("R6 fwd low", fwdIrq & ~FWD, 32'd0);

    // Pseudo-random sources and enables
    lfsr = 32'hACE1_1234;
    for (int n = 0; n < 96; n++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      en = lfsr ^ 32'h5A5A_0F0F;
      busWrite(3'd0, en);
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      applyAndCheck(lfsr, en, "R3 random");
      check("R6 random", fwdIrq & ~FWD, 32'd0);
      busRead(3'd4, rd, vld);
      check("R7 status", rd, lfsr);
      check("R8 valid", {31'd0, vld}, 32'd1);
      busRead(3'd0, rd, vld);
      check("R8 enable read", rd, en);
    end

    // R8: unused offsets read zero
    for (int a = 0; a < 8; a++) begin
      if (a != 0 && a != 4) begin
        busRead(3'(a), rd, vld);
        check("R8 unused offset", rd, 32'd0);
      end
    end
    // R7: status unaffected by a status-offset write
    srcIrq = 32'h1234_8765;
    busWrite(3'd4, 32'hFFFF_FFFF);
    busRead(3'd4, rd, vld);
    check("R7 status after write", rd, 32'h1234_8765);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule